// File: doc/BRIEF.md
# Synchronous ROM Burst Read Engine

This block is the device-side read path of a clocked read-only memory. A two-bit command is sampled on every rising clock edge together with a column address. A READ starts a burst of four data words. The words come out on a 16-bit data bus after a programmable column latency of 2, 3 or 4 clocks. A separate enable output marks when the bus is driven. When it is low the bus is treated as high impedance and the data lines read as zero.

A burst in flight can be cut short in two ways. A new READ drops every word of the old burst that has not yet been scheduled, and the new burst follows the last scheduled word with no gap. A BURST STOP or PRECHARGE lets the words already scheduled drain, then releases the bus. Every memory word is a fixed arithmetic function of its column address, so a host model can predict each word on the bus. The latency setting is taken only while the engine is idle.

Top module: `srom_burst`

## Requirements
- R1: During and after reset, with only NOP commands applied, dq_oe is 0 and dq is all zeros.
- R2: Timing is defined as follows. A READ is sampled at rising edge n. With latency CL, word i of its burst (i = 0..3) is on dq with dq_oe high during the clock period that ends at edge n+CL+i. Under R11, CL is 2, 3 or 4.
- R3: The burst walks the aligned group of four columns that holds the start column. The low two address bits go start, start+1, start+2, start+3 modulo 4, and the upper bits stay fixed.
- R4: The word for column a is bits 15:0 of (a × 40503) XOR 0x5A3C.
- R5: The command encoding is NOP = 0, READ = 1, PRECHARGE = 2, BURST STOP = 3. Suppose a READ is sampled at edge k and another READ at edge k+d, with 1 ≤ d ≤ 3. Then only words 0..d-1 of the first burst are output, and the second burst's word 0 follows directly in the next period.
- R6: Suppose a BURST STOP or PRECHARGE is sampled at edge s while a burst is active. Words already scheduled before edge s are still output. dq_oe is low in the period ending at edge s+CL and afterwards, unless a later READ drives the bus again. PRECHARGE and BURST STOP behave identically.
- R7: If a BURST STOP or PRECHARGE is sampled one edge after a READ, exactly one word (word 0) of that burst is output.
- R8: A BURST STOP or PRECHARGE with no burst in flight leaves dq_oe low and does not affect a later READ.
- R9: The latency input is taken only when no burst is active and no word is in flight. A change in the middle of a burst does not alter that burst's timing, and the new value applies to the next burst.
- R10: Whenever dq_oe is low, dq is all zeros.
- R11: Latency input values below 2 behave as 2, and values above 4 behave as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 0 NOP, 1 READ, 2 PRECHARGE, 3 BURST STOP |
| col | input | COL_W (8) | Start column address, sampled with READ |
| lat | input | 3 | Requested column latency (2..4, clamped) |
| dq | output | DATA_W (16) | Read data, zero while not driven |
| dq_oe | output | 1 | High while the data bus is driven |

## Verification
The bench sweeps every latency code against every start offset within a group. A design that wrapped the address out of its group, or miscounted the pipeline by one register, would shift or corrupt whole bursts. READ-on-READ is tested at spacings of one to four clocks, including three READs back to back. An engine that left a gap, or let an extra old word through, would misplace the new burst's first word. STOP and PRECHARGE are each issued one to four clocks into a burst. A model that released the bus at CL-1 or CL+1, or that lost the single word of a stop given one clock after a READ, would miss an enable edge. Two further cases cover a latency change in the middle of a burst and a stop issued while idle. A design that sampled the latency too eagerly would stretch a burst in flight, and one that reacted to an idle stop would disturb the next READ.

// File: rtl/srom_burst.sv
module srom_burst #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 4,
  parameter int BURST  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     cmd,
  input  logic [COL_W-1:0]               col,
  input  logic [$clog2(CL_MAX+1)-1:0]    lat,
  output logic [DATA_W-1:0]              dq,
  output logic                           dq_oe
);
  localparam int OFF_W = $clog2(BURST);
  localparam int CLW   = $clog2(CL_MAX+1);
  localparam int IDX_W = $clog2(CL_MAX);
  localparam logic [1:0] C_NOP  = 2'd0;
  localparam logic [1:0] C_READ = 2'd1;

  function automatic logic [DATA_W-1:0] rom_word(input logic [COL_W-1:0] a);
    logic [31:0] x;
    x = (32'(a) * 32'd40503) ^ 32'h5A3C;
    return x[DATA_W-1:0];
  endfunction

  logic [OFF_W-1:0]       rem, off;
  logic [COL_W-OFF_W-1:0] base;
  logic [CLW-1:0]         lat_r, lat_c;
  logic [CL_MAX-1:0]      pv;
  logic [DATA_W-1:0]      pd [CL_MAX];

  logic             is_rd, is_term, iss_v, idle;
  logic [COL_W-1:0] iss_a;
  logic [IDX_W-1:0] tap;

  assign is_rd   = cmd == C_READ;
  assign is_term = !is_rd && cmd != C_NOP;
  assign iss_v   = is_rd || (rem != '0 && cmd == C_NOP);
  assign iss_a   = is_rd ? col : {base, off};
  assign idle    = rem == '0 && pv == '0 && !is_rd;
  assign lat_c   = (lat < CLW'(CL_MIN)) ? CLW'(CL_MIN) :
                   (lat > CLW'(CL_MAX)) ? CLW'(CL_MAX) : lat;
  assign tap     = IDX_W'(lat_r - 1'b1);
  assign dq_oe   = pv[tap];
  assign dq      = dq_oe ? pd[tap] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_r <= CLW'(CL_MAX);
    else if (idle) lat_r <= lat_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      off  <= '0;
      base <= '0;
    end else if (is_rd) begin
      rem  <= OFF_W'(BURST-1);
      base <= col[COL_W-1:OFF_W];
      off  <= col[OFF_W-1:0] + 1'b1;
    end else if (is_term) begin
      rem <= '0;
    end else if (rem != '0) begin
      rem <= rem - 1'b1;
      off <= off + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int k = 0; k < CL_MAX; k++) pd[k] <= '0;
    end else begin
      pv    <= {pv[CL_MAX-2:0], iss_v};
      pd[0] <= iss_v ? rom_word(iss_a) : '0;
      for (int k = 1; k < CL_MAX; k++) pd[k] <= pd[k-1];
    end
  end
endmodule

module srom_burst_chk #(
  parameter int DATA_W = 16,
  parameter int CL_MAX = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  cmd,
  input logic [DATA_W-1:0]           dq,
  input logic                        dq_oe,
  input logic [$clog2(CL_MAX+1)-1:0] lat_r
);
  localparam int IDX_W = $clog2(CL_MAX);
  logic [CL_MAX-1:0] rd_h, st_h, mask;
  logic [IDX_W-1:0]  tap;
  logic [3:0]        since;
  logic              is_term;

  assign is_term = cmd == 2'd2 || cmd == 2'd3;
  assign tap     = IDX_W'(lat_r - 1'b1);
  assign mask    = (CL_MAX'(1) << tap) - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_h  <= '0;
      st_h  <= '0;
      since <= 4'hF;
    end else begin
      rd_h  <= {rd_h[CL_MAX-2:0], cmd == 2'd1};
      st_h  <= {st_h[CL_MAX-2:0], is_term};
      since <= (cmd == 2'd1) ? 4'd0 : (since == 4'hF ? since : since + 1'b1);
    end
  end

  a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    rd_h[tap] |-> dq_oe);
  a_r6_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_h[tap] && (rd_h & mask) == '0) |-> !dq_oe);
  a_r8_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (is_term && since >= 4'd8) |=> !dq_oe);
  a_r9_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_r) |-> !dq_oe);
  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq == '0);
endmodule

bind srom_burst srom_burst_chk #(.DATA_W(DATA_W), .CL_MAX(CL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .dq(dq), .dq_oe(dq_oe), .lat_r(lat_r)
);

// File: tb/srom_burst_bench.sv
module srom_burst_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] cmd = 0;
  logic [7:0] col = 0;
  logic [2:0] lat = 3'd2;
  logic [15:0] dq;
  logic dq_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] sc_cmd [0:15];
  logic [7:0] sc_col [0:15];
  int sc_n;
  bit ev [0:47];
  logic [15:0] ed [0:47];

  srom_burst u_srom_burst (.clk(clk), .rst_n(rst_n), .cmd(cmd), .col(col),
                           .lat(lat), .dq(dq), .dq_oe(dq_oe));

  always #2 clk = ~clk;

  function automatic logic [15:0] romw(input logic [7:0] a);
    logic [31:0] x;
    x = (32'(a) * 32'd40503) ^ 32'h5A3C;
    return x[15:0];
  endfunction

  function automatic int eff(input int l);
    return l < 2 ? 2 : (l > 4 ? 4 : l);
  endfunction

  task automatic chk(input string tag, input logic e_oe, input logic [15:0] e_d);
    checks++;
    if (dq_oe !== e_oe || dq !== e_d) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b dq=%h expected dq_oe=%0b dq=%h", tag, dq_oe, dq, e_oe, e_d);
    end
  endtask

  task automatic clr();
    sc_n = 0;
    for (int i = 0; i < 16; i++) begin sc_cmd[i] = 2'd0; sc_col[i] = 8'd0; end
  endtask

  task automatic put(input int at, input logic [1:0] c, input logic [7:0] a);
    sc_cmd[at] = c; sc_col[at] = a;
    if (at + 1 > sc_n) sc_n = at + 1;
  endtask

  task automatic run(input string tag, input int lat_in, input int mid_at, input int lat_mid);
    int cl;
    cl = eff(lat_in);
    for (int i = 0; i < 48; i++) begin ev[i] = 0; ed[i] = 16'h0; end
    for (int k = 0; k < sc_n; k++) begin
      if (sc_cmd[k] == 2'd1) begin
        for (int i = 0; i < 4; i++) begin
          bit cut = 0;
          for (int j = 1; j <= i; j++)
            if (k + j < sc_n && sc_cmd[k+j] != 2'd0) cut = 1;
          if (!cut) begin
            ev[k+cl+i] = 1;
            ed[k+cl+i] = romw({sc_col[k][7:2], 2'(sc_col[k][1:0] + 2'(i))});
          end
        end
      end
    end
    @(negedge clk);
    cmd = 2'd0; lat = 3'(lat_in);
    repeat (8) @(negedge clk);
    for (int m = 0; m < sc_n + 12; m++) begin
      if (m >= 1) chk(ev[m] ? tag : {tag, " R10"}, ev[m], ed[m]);
      cmd = (m < sc_n) ? sc_cmd[m] : 2'd0;
      col = (m < sc_n) ? sc_col[m] : 8'd0;
      if (m == mid_at) lat = 3'(lat_mid);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 16'h0);
    rst_n = 1;
    repeat (3) begin @(negedge clk); chk("R1 after reset", 1'b0, 16'h0); end

    for (int l = 0; l < 8; l++)
      for (int o = 0; o < 4; o++) begin
        clr(); put(0, 2'd1, 8'((l * 52 + 16) & 8'hFC) | 8'(o));
        run((l >= 2 && l <= 4) ? "R2 R3 R4 single" : "R11 clamp", l, -1, 0);
      end

    for (int l = 2; l <= 4; l++)
      for (int d = 1; d <= 4; d++) begin
        clr(); put(0, 2'd1, 8'h15); put(d, 2'd1, 8'hA2);
        run("R5 read-on-read", l, -1, 0);
      end
    for (int l = 2; l <= 4; l++) begin
      clr(); put(0, 2'd1, 8'h07); put(1, 2'd1, 8'h31); put(2, 2'd1, 8'hCE);
      run("R5 triple read", l, -1, 0);
    end

    for (int l = 2; l <= 4; l++)
      for (int c = 2; c <= 3; c++)
        for (int d = 1; d <= 4; d++) begin
          clr(); put(0, 2'd1, 8'h5B); put(d, 2'(c), 8'h00);
          run(d == 1 ? "R7 early stop" : "R6 stop/precharge", l, -1, 0);
        end

    for (int l = 2; l <= 4; l++) begin
      clr(); put(0, 2'd3, 8'h00); put(1, 2'd2, 8'h00); put(3, 2'd1, 8'h6E);
      run("R8 idle stop", l, -1, 0);
    end

    clr(); put(0, 2'd1, 8'h2C); run("R9 mid change to 4", 2, 1, 4);
    clr(); put(0, 2'd1, 8'h2D); run("R9 new lat 4", 4, -1, 0);
    clr(); put(0, 2'd1, 8'h93); run("R9 mid change to 2", 4, 2, 2);
    clr(); put(0, 2'd1, 8'h90); run("R9 new lat 2", 2, -1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
      $finish;
    end
  end
endmodule